// File: doc/BRIEF.md
# IPv4 Forwarding Decision and Header Rewrite Stage

This block sits in a packet pipeline between an input arbiter and the output queues. Packets arrive on a 256-bit AXI4-Stream slave with a 128-bit TUSER sideband and leave on an AXI4-Stream master. For each packet the stage chooses an egress port and writes it into the sideband. Packets that can be routed in hardware also get their Ethernet and IPv4 headers rewritten. Packets that software must handle are steered to a host port without change, and malformed packets are discarded.

The Ethernet and IPv4 header takes 34 bytes, so it spans the first two beats. The stage holds both beats and stalls its input while two lookup cycles run. The first cycle does a longest-prefix match on the destination address. The second resolves the next-hop hardware address and settles the final action. The stage then replays the two held beats and passes the rest of the packet straight through.

An 8-entry route table and an 8-entry neighbour table are loaded through simple write strobes. Each MAC port has its own hardware address: the parameter base address plus the port index.

Top module: `ipv4_port_lookup`

## Requirements
- R1: Sideband fields: TUSER[15:0] is the packet length, TUSER[23:16] the one-hot source port and TUSER[31:24] the one-hot destination port. Bit 2p stands for MAC port p and bit 2p+1 for the host port paired with MAC port p. Only TUSER[31:24] is rewritten, and every output beat carries the same sideband value.
- R2: Bus byte k sits in TDATA[8k+7:8k]. A packet from a MAC port is dropped whole, with no output beats, if its destination hardware address (bytes 0 to 5, byte 0 most significant) differs from the address of its ingress port.
- R3: Three kinds of packet from a MAC port go unmodified to the paired host port: those whose ethertype (bytes 12 and 13) is not 0x0800, those whose byte 14 is not 0x45 (version 4, five-word header), and those that end in their first beat.
- R4: A packet whose IPv4 header checksum (bytes 14 to 33) does not verify is dropped whole.
- R5: A valid packet whose TTL (byte 22) is 0 or 1 goes unmodified to the paired host port.
- R6: The route lookup considers only valid entries with (dst_ip ^ prefix) & mask == 0, where the destination address is bytes 30 to 33. Among those it picks the entry with the most mask bits set, and the lowest index on a tie. If no entry matches, the packet goes unmodified to the paired host port.
- R7: The next hop is the route's next-hop address, or the destination address when that field is zero. If no valid neighbour entry holds the next-hop address, the packet goes unmodified to the paired host port.
- R8: A forwarded packet leaves on MAC port q, where q is the route's port field. Bytes 0 to 5 become the neighbour's hardware address and bytes 6 to 11 become the address of port q. TTL drops by one and the checksum is patched so the header verifies again.
- R9: A packet from a host port skips every check and goes unmodified to the paired MAC port.
- R10: Beats after the second pass through unchanged, and TLAST is preserved on every beat.
- R11: While the output is valid and not ready, the output beat stays stable. No beat is lost or duplicated under backpressure.
- R12: After reset the output is not valid and the input is ready for a first beat.
- R13: A table write takes effect for the next packet. An entry written with its valid bit clear takes no part in lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tdata | input | DATA_W | Input stream data |
| s_tuser | input | USER_W | Input sideband |
| s_tlast | input | 1 | Input end of packet |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| m_tdata | output | DATA_W | Output stream data |
| m_tuser | output | USER_W | Output sideband with destination rewritten |
| m_tlast | output | 1 | Output end of packet |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream ready |
| rt_we | input | 1 | Route entry write strobe |
| rt_idx | input | log2(RT_DEPTH) | Route entry index |
| rt_valid | input | 1 | Route entry valid bit |
| rt_prefix | input | 32 | Route prefix |
| rt_mask | input | 32 | Route mask |
| rt_nexthop | input | 32 | Next-hop address (0 means directly attached) |
| rt_port | input | 2 | Egress MAC port index |
| arp_we | input | 1 | Neighbour entry write strobe |
| arp_idx | input | log2(ARP_DEPTH) | Neighbour entry index |
| arp_valid | input | 1 | Neighbour entry valid bit |
| arp_ip | input | 32 | Neighbour IPv4 address |
| arp_mac | input | 48 | Neighbour hardware address |

## Verification
A corrupted action register or table entry shows up as a wrong one-hot destination in the sideband on the first output beat of the affected packet. It can also show up as a packet that appears when it should have been dropped, or is missing when it should have arrived, about six cycles after the header beats are accepted. A slip in the byte offsets of the rewrite shows as a header that no longer verifies, or as a wrong TTL or wrong addresses in the first output beat. A broken state sequence shows as lost, duplicated or reordered beats within the same packet, or as the stream hanging at the next packet boundary.

// File: rtl/ipv4_port_lookup.sv
module ipv4_port_lookup #(
  parameter int DATA_W = 256,
  parameter int USER_W = 128,
  parameter int RT_DEPTH = 8,
  parameter int ARP_DEPTH = 8,
  parameter logic [47:0] MAC_BASE = 48'h02_53_00_00_00_00
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DATA_W-1:0]            s_tdata,
  input  logic [USER_W-1:0]            s_tuser,
  input  logic                         s_tlast,
  input  logic                         s_tvalid,
  output logic                         s_tready,
  output logic [DATA_W-1:0]            m_tdata,
  output logic [USER_W-1:0]            m_tuser,
  output logic                         m_tlast,
  output logic                         m_tvalid,
  input  logic                         m_tready,
  input  logic                         rt_we,
  input  logic [$clog2(RT_DEPTH)-1:0]  rt_idx,
  input  logic                         rt_valid,
  input  logic [31:0]                  rt_prefix,
  input  logic [31:0]                  rt_mask,
  input  logic [31:0]                  rt_nexthop,
  input  logic [1:0]                   rt_port,
  input  logic                         arp_we,
  input  logic [$clog2(ARP_DEPTH)-1:0] arp_idx,
  input  logic                         arp_valid,
  input  logic [31:0]                  arp_ip,
  input  logic [47:0]                  arp_mac
);
  localparam int RT_AW  = $clog2(RT_DEPTH);
  localparam int ARP_AW = $clog2(ARP_DEPTH);

  typedef enum logic [2:0] {
    S_HDR0, S_HDR1, S_LPM, S_ARP, S_OUT0, S_OUT1, S_BODY, S_DROP
  } state_t;
  state_t st;

  // tables
  logic        rt_v  [RT_DEPTH];
  logic [31:0] rt_pfx[RT_DEPTH];
  logic [31:0] rt_msk[RT_DEPTH];
  logic [31:0] rt_nh [RT_DEPTH];
  logic [1:0]  rt_pt [RT_DEPTH];
  logic        nb_v  [ARP_DEPTH];
  logic [31:0] nb_ip [ARP_DEPTH];
  logic [47:0] nb_mac[ARP_DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < RT_DEPTH; i++) rt_v[i] <= 1'b0;
      for (int i = 0; i < ARP_DEPTH; i++) nb_v[i] <= 1'b0;
    end else begin
      if (rt_we)  rt_v[rt_idx]  <= rt_valid;
      if (arp_we) nb_v[arp_idx] <= arp_valid;
    end

  always_ff @(posedge clk) begin
    if (rt_we) begin
      rt_pfx[rt_idx] <= rt_prefix;
      rt_msk[rt_idx] <= rt_mask;
      rt_nh[rt_idx]  <= rt_nexthop;
      rt_pt[rt_idx]  <= rt_port;
    end
    if (arp_we) begin
      nb_ip[arp_idx]  <= arp_ip;
      nb_mac[arp_idx] <= arp_mac;
    end
  end

  // held header beats
  logic [DATA_W-1:0] b0, b1;
  logic [USER_W-1:0] usr;
  logic              short_pkt, last1;

  // parsed fields
  logic [47:0] hdr_dmac;
  logic [15:0] hdr_etype, hdr_csum;
  logic [7:0]  hdr_vihl, hdr_ttl;
  logic [31:0] hdr_dip;
  assign hdr_dmac  = {b0[7:0], b0[15:8], b0[23:16], b0[31:24], b0[39:32], b0[47:40]};
  assign hdr_etype = {b0[103:96], b0[111:104]};
  assign hdr_vihl  = b0[119:112];
  assign hdr_ttl   = b0[183:176];
  assign hdr_csum  = {b0[199:192], b0[207:200]};
  assign hdr_dip   = {b0[247:240], b0[255:248], b1[7:0], b1[15:8]};

  // header checksum verification
  logic [19:0] hsum;
  logic [16:0] hfold1;
  logic [16:0] hfold2;
  logic        csum_ok;
  always_comb begin
    hsum = 20'({b1[7:0], b1[15:8]});
    for (int j = 7; j < 16; j++)
      hsum = hsum + 20'({b0[16*j +: 8], b0[16*j+8 +: 8]});
  end
  assign hfold1  = 17'(hsum[15:0]) + 17'(hsum[19:16]);
  assign hfold2  = 17'(hfold1[15:0]) + 17'(hfold1[16]);
  assign csum_ok = hfold2[15:0] == 16'hFFFF;

  // ingress port
  logic [7:0]  src_oh;
  logic [1:0]  in_idx;
  logic        from_cpu;
  logic [47:0] in_mac;
  assign src_oh   = usr[23:16];
  assign from_cpu = |(src_oh & 8'hAA);
  always_comb begin
    in_idx = 2'd0;
    for (int p = 0; p < 4; p++)
      if (src_oh[2*p] | src_oh[2*p+1]) in_idx = 2'(p);
  end
  assign in_mac = MAC_BASE + 48'(in_idx);

  // longest prefix match
  logic             lpm_hit;
  logic [5:0]       lpm_len;
  logic [RT_AW-1:0] lpm_sel;
  always_comb begin
    lpm_hit = 1'b0;
    lpm_len = 6'd0;
    lpm_sel = '0;
    for (int i = 0; i < RT_DEPTH; i++)
      if (rt_v[i] && (((hdr_dip ^ rt_pfx[i]) & rt_msk[i]) == 32'd0) &&
          (!lpm_hit || 6'($countones(rt_msk[i])) > lpm_len)) begin
        lpm_hit = 1'b1;
        lpm_len = 6'($countones(rt_msk[i]));
        lpm_sel = RT_AW'(i);
      end
  end

  logic        r_hit;
  logic [31:0] r_nh;
  logic [1:0]  r_port;

  // neighbour lookup
  logic        nb_hit;
  logic [47:0] nb_sel_mac;
  always_comb begin
    nb_hit     = 1'b0;
    nb_sel_mac = 48'd0;
    for (int i = ARP_DEPTH - 1; i >= 0; i--)
      if (nb_v[i] && nb_ip[i] == r_nh) begin
        nb_hit     = 1'b1;
        nb_sel_mac = nb_mac[i];
      end
  end

  // decision
  logic       dec_drop, dec_fwd;
  logic [7:0] dec_dst;
  always_comb begin
    dec_drop = 1'b0;
    dec_fwd  = 1'b0;
    dec_dst  = 8'b10 << {in_idx, 1'b0};
    if (from_cpu)
      dec_dst = 8'b01 << {in_idx, 1'b0};
    else if (hdr_dmac != in_mac)
      dec_drop = 1'b1;
    else if (short_pkt || hdr_etype != 16'h0800 || hdr_vihl != 8'h45)
      dec_fwd = 1'b0;
    else if (!csum_ok)
      dec_drop = 1'b1;
    else if (hdr_ttl <= 8'd1)
      dec_fwd = 1'b0;
    else if (r_hit && nb_hit) begin
      dec_fwd = 1'b1;
      dec_dst = 8'b01 << {r_port, 1'b0};
    end
  end

  logic        fwd;
  logic [7:0]  dst_oh;
  logic [47:0] nh_mac;
  logic [1:0]  eg_port;

  // header rewrite
  logic [47:0]       eg_mac;
  logic [16:0]       csum_inc;
  logic [15:0]       new_csum;
  logic [DATA_W-1:0] mod0;
  assign eg_mac   = MAC_BASE + 48'(eg_port);
  assign csum_inc = 17'(hdr_csum) + 17'h00100;
  assign new_csum = csum_inc[15:0] + 16'(csum_inc[16]);
  always_comb begin
    mod0 = b0;
    for (int k = 0; k < 6; k++) begin
      mod0[8*k +: 8]      = nh_mac[47-8*k -: 8];
      mod0[48+8*k +: 8]   = eg_mac[47-8*k -: 8];
    end
    mod0[183:176] = hdr_ttl - 8'd1;
    mod0[199:192] = new_csum[15:8];
    mod0[207:200] = new_csum[7:0];
  end

  // control
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_HDR0;
      b0        <= '0;
      b1        <= '0;
      usr       <= '0;
      short_pkt <= 1'b0;
      last1     <= 1'b0;
      r_hit     <= 1'b0;
      r_nh      <= 32'd0;
      r_port    <= 2'd0;
      fwd       <= 1'b0;
      dst_oh    <= 8'd0;
      nh_mac    <= 48'd0;
      eg_port   <= 2'd0;
    end else begin
      case (st)
        S_HDR0: if (s_tvalid) begin
          b0        <= s_tdata;
          b1        <= '0;
          usr       <= s_tuser;
          short_pkt <= s_tlast;
          last1     <= 1'b1;
          st        <= s_tlast ? S_LPM : S_HDR1;
        end
        S_HDR1: if (s_tvalid) begin
          b1    <= s_tdata;
          last1 <= s_tlast;
          st    <= S_LPM;
        end
        S_LPM: begin
          r_hit  <= lpm_hit;
          r_nh   <= (rt_nh[lpm_sel] == 32'd0) ? hdr_dip : rt_nh[lpm_sel];
          r_port <= rt_pt[lpm_sel];
          st     <= S_ARP;
        end
        S_ARP: begin
          fwd     <= dec_fwd;
          dst_oh  <= dec_dst;
          nh_mac  <= nb_sel_mac;
          eg_port <= r_port;
          if (dec_drop) st <= last1 ? S_HDR0 : S_DROP;
          else          st <= S_OUT0;
        end
        S_OUT0: if (m_tready) st <= short_pkt ? S_HDR0 : S_OUT1;
        S_OUT1: if (m_tready) st <= last1 ? S_HDR0 : S_BODY;
        S_BODY: if (s_tvalid && m_tready && s_tlast) st <= S_HDR0;
        S_DROP: if (s_tvalid && s_tlast) st <= S_HDR0;
        default: st <= S_HDR0;
      endcase
    end

  assign s_tready = (st == S_HDR0) || (st == S_HDR1) || (st == S_DROP) ||
                    (st == S_BODY && m_tready);
  assign m_tvalid = (st == S_OUT0) || (st == S_OUT1) || (st == S_BODY && s_tvalid);
  assign m_tdata  = (st == S_OUT0) ? (fwd ? mod0 : b0) :
                    (st == S_OUT1) ? b1 : s_tdata;
  assign m_tlast  = (st == S_OUT0) ? short_pkt :
                    (st == S_OUT1) ? last1 : s_tlast;
  assign m_tuser  = {usr[USER_W-1:32], dst_oh, usr[23:0]};
endmodule

// File: rtl/ipv4_port_lookup_chk.sv
module ipv4_port_lookup_chk #(
  parameter int DATA_W = 256,
  parameter int USER_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] m_tdata,
  input logic [USER_W-1:0] m_tuser,
  input logic              m_tlast,
  input logic              m_tvalid,
  input logic              m_tready
);
  logic sof;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sof <= 1'b1;
    else if (m_tvalid && m_tready) sof <= m_tlast;

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast) && $stable(m_tuser));

  p_dst_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> $onehot(m_tuser[31:24]));

  p_host_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && |(m_tuser[23:16] & 8'hAA) |-> m_tuser[31:24] == (m_tuser[23:16] >> 1));

  p_host_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && |(m_tuser[31:24] & 8'hAA) |-> m_tuser[31:24] == (m_tuser[23:16] << 1));

  p_fwd_ttl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && sof && |(m_tuser[23:16] & 8'h55) && |(m_tuser[31:24] & 8'h55)
    |-> m_tdata[183:176] != 8'd0);
endmodule

bind ipv4_port_lookup ipv4_port_lookup_chk #(.DATA_W(DATA_W), .USER_W(USER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_tdata(m_tdata), .m_tuser(m_tuser),
  .m_tlast(m_tlast), .m_tvalid(m_tvalid), .m_tready(m_tready));

// File: tb/ipv4_port_lookup_test.sv
module ipv4_port_lookup_test;
  localparam logic [47:0] MB    = 48'h02_53_00_00_00_00;
  localparam logic [95:0] SLOTS = 96'h1111_2222_3333_4444_5555_6666;
  localparam logic [47:0] MAC_A = 48'hA0_A1_A2_A3_A4_A5;
  localparam logic [47:0] MAC_B = 48'hB0_B1_B2_B3_B4_B5;
  localparam logic [47:0] MAC_C = 48'hC0_C1_C2_C3_C4_C5;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [255:0] s_tdata = '0, m_tdata;
  logic [127:0] s_tuser = '0, m_tuser;
  logic s_tlast = 0, s_tvalid = 0, s_tready, m_tlast, m_tvalid, m_tready = 1;
  logic rt_we = 0, rt_valid = 0, arp_we = 0, arp_valid = 0;
  logic [2:0] rt_idx = 0, arp_idx = 0;
  logic [31:0] rt_prefix = 0, rt_mask = 0, rt_nexthop = 0, arp_ip = 0;
  logic [1:0] rt_port = 0;
  logic [47:0] arp_mac = 0;

  ipv4_port_lookup #(.MAC_BASE(MB)) uut (.*);

  int n_chk = 0, n_fail = 0;
  logic [7:0] pb[96];
  logic [7:0] eb[96];
  int plen;
  bit bp = 0;

  logic [255:0] rx_data[16];
  logic [127:0] rx_user[16];
  logic         rx_last[16];
  int rx_n = 0;

  initial forever begin
    @(negedge clk);
    if (m_tvalid && m_tready) begin
      if (rx_n < 16) begin
        rx_data[rx_n] = m_tdata;
        rx_user[rx_n] = m_tuser;
        rx_last[rx_n] = m_tlast;
      end
      rx_n++;
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      m_tready = bp ? (cyc % 3 != 2) : 1'b1;
      cyc++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] csum(input logic [159:0] h);
    logic [19:0] s = 0;
    for (int i = 0; i < 10; i++) s += 20'(h[159-16*i -: 16]);
    s = 20'(s[15:0]) + 20'(s[19:16]);
    s = 20'(s[15:0]) + 20'(s[19:16]);
    return ~s[15:0];
  endfunction

  task automatic make_pkt(input logic [47:0] dmac, input logic [15:0] etype,
                          input logic [7:0] vihl, input logic [7:0] ttl,
                          input logic [31:0] dip, input bit good, input int len);
    logic [159:0] h;
    logic [15:0] cs;
    for (int i = 0; i < 96; i++) pb[i] = 8'(i * 5 + 1);
    for (int k = 0; k < 6; k++) begin
      pb[k]   = dmac[47-8*k -: 8];
      pb[6+k] = 8'(8'h10 + k);
    end
    pb[12] = etype[15:8]; pb[13] = etype[7:0];
    pb[14] = vihl; pb[15] = 8'h00; pb[16] = 8'h00; pb[17] = 8'(len - 14);
    pb[18] = 8'h12; pb[19] = 8'h34; pb[20] = 8'h40; pb[21] = 8'h00;
    pb[22] = ttl; pb[23] = 8'd17; pb[24] = 8'h00; pb[25] = 8'h00;
    pb[26] = 8'hC0; pb[27] = 8'h00; pb[28] = 8'h02; pb[29] = 8'h09;
    for (int k = 0; k < 4; k++) pb[30+k] = dip[31-8*k -: 8];
    for (int i = 0; i < 20; i++) h[159-8*i -: 8] = pb[14+i];
    cs = csum(h);
    if (!good) cs ^= 16'h0101;
    pb[24] = cs[15:8]; pb[25] = cs[7:0];
    for (int i = 0; i < 96; i++) if (i >= len) pb[i] = 8'h00;
    plen = len;
    for (int i = 0; i < 96; i++) eb[i] = pb[i];
  endtask

  task automatic prep_fwd(input logic [47:0] mac, input logic [1:0] port);
    logic [159:0] h;
    logic [15:0] cs;
    logic [47:0] pm = MB + 48'(port);
    for (int k = 0; k < 6; k++) begin
      eb[k]   = mac[47-8*k -: 8];
      eb[6+k] = pm[47-8*k -: 8];
    end
    eb[22] = eb[22] - 8'd1;
    eb[24] = 8'h00; eb[25] = 8'h00;
    for (int i = 0; i < 20; i++) h[159-8*i -: 8] = eb[14+i];
    cs = csum(h);
    eb[24] = cs[15:8]; eb[25] = cs[7:0];
  endtask

  task automatic send_pkt(input logic [7:0] src);
    int nb = (plen + 31) / 32;
    @(posedge clk); #1;
    for (int j = 0; j < nb; j++) begin
      for (int b = 0; b < 32; b++) s_tdata[8*b +: 8] = pb[32*j + b];
      s_tuser  = {SLOTS, 8'h00, src, 16'(plen)};
      s_tlast  = (j == nb - 1);
      s_tvalid = 1'b1;
      @(negedge clk);
      while (!s_tready) @(negedge clk);
      @(posedge clk); #1;
    end
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
  endtask

  task automatic run_pkt(input logic [7:0] src, input bit drop,
                         input logic [7:0] dst, input string req);
    int nb = (plen + 31) / 32;
    logic [255:0] ed;
    rx_n = 0;
    send_pkt(src);
    repeat (40) @(posedge clk);
    if (drop) begin
      chk(rx_n == 0, req, "beats out", 256'(rx_n), 256'(0));
      return;
    end
    chk(rx_n == nb, req, "beat count", 256'(rx_n), 256'(nb));
    for (int j = 0; j < nb && j < rx_n; j++) begin
      for (int b = 0; b < 32; b++) ed[8*b +: 8] = eb[32*j + b];
      chk(rx_data[j] == ed, req, "data", rx_data[j], ed);
      chk(rx_user[j] == {SLOTS, dst, src, 16'(plen)}, req, "tuser",
          256'(rx_user[j]), 256'({SLOTS, dst, src, 16'(plen)}));
      chk(rx_last[j] == (j == nb - 1), req, "tlast", 256'(rx_last[j]), 256'(j == nb - 1));
    end
  endtask

  task automatic wr_route(input int i, input bit v, input logic [31:0] pfx,
                          input logic [31:0] msk, input logic [31:0] nh, input logic [1:0] pt);
    @(posedge clk); #1;
    rt_we = 1; rt_idx = 3'(i); rt_valid = v; rt_prefix = pfx;
    rt_mask = msk; rt_nexthop = nh; rt_port = pt;
    @(posedge clk); #1;
    rt_we = 0;
  endtask

  task automatic wr_arp(input int i, input logic [31:0] ip, input logic [47:0] mac);
    @(posedge clk); #1;
    arp_we = 1; arp_idx = 3'(i); arp_valid = 1; arp_ip = ip; arp_mac = mac;
    @(posedge clk); #1;
    arp_we = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(m_tvalid == 0, "R12", "m_tvalid", 256'(m_tvalid), 256'(0));
    chk(s_tready == 1, "R12", "s_tready", 256'(s_tready), 256'(1));
  endtask

  task automatic t_tables;
    wr_route(0, 1, 32'h0A00_0000, 32'hFF00_0000, 32'hC0A8_0101, 2'd1);
    wr_route(1, 1, 32'h0A01_0000, 32'hFFFF_0000, 32'h0000_0000, 2'd2);
    wr_route(2, 1, 32'h0A01_0200, 32'hFFFF_FF00, 32'hC0A8_0303, 2'd3);
    wr_route(3, 0, 32'h0A01_0280, 32'hFFFF_FF80, 32'hC0A8_0101, 2'd0);
    wr_arp(0, 32'hC0A8_0101, MAC_A);
    wr_arp(1, 32'h0A01_0505, MAC_B);
    wr_arp(2, 32'hC0A8_0303, MAC_C);
  endtask

  task automatic t_fwd_basic;  // R8 R10 R1
    make_pkt(MB + 0, 16'h0800, 8'h45, 8'd64, 32'h0A09_0909, 1, 90);
    prep_fwd(MAC_A, 2'd1);
    run_pkt(8'h01, 0, 8'h04, "R8");
  endtask

  task automatic t_lpm;  // R6 R13 (invalid /25 ignored)
    make_pkt(MB + 1, 16'h0800, 8'h45, 8'd20, 32'h0A01_02C8, 1, 64);
    prep_fwd(MAC_C, 2'd3);
    run_pkt(8'h04, 0, 8'h40, "R6");
  endtask

  task automatic t_direct;  // R7
    make_pkt(MB + 2, 16'h0800, 8'h45, 8'd2, 32'h0A01_0505, 1, 64);
    prep_fwd(MAC_B, 2'd2);
    run_pkt(8'h10, 0, 8'h10, "R7");
  endtask

  task automatic t_misses;
    make_pkt(MB + 0, 16'h0800, 8'h45, 8'd64, 32'h0A01_0707, 1, 64);
    run_pkt(8'h01, 0, 8'h02, "R7");
    make_pkt(MB + 3, 16'h0800, 8'h45, 8'd64, 32'h0B00_0001, 1, 70);
    run_pkt(8'h40, 0, 8'h80, "R6");
  endtask

  task automatic t_ttl;  // R5
    make_pkt(MB + 1, 16'h0800, 8'h45, 8'd1, 32'h0A09_0909, 1, 64);
    run_pkt(8'h04, 0, 8'h08, "R5");
    make_pkt(MB + 2, 16'h0800, 8'h45, 8'd0, 32'h0A09_0909, 1, 64);
    run_pkt(8'h10, 0, 8'h20, "R5");
  endtask

  task automatic t_drops;
    make_pkt(MB + 0, 16'h0800, 8'h45, 8'd64, 32'h0A09_0909, 0, 90);
    run_pkt(8'h01, 1, 8'h00, "R4");
    make_pkt(MB + 1, 16'h0800, 8'h45, 8'd64, 32'h0A09_0909, 1, 64);
    run_pkt(8'h01, 1, 8'h00, "R2");
  endtask

  task automatic t_nonip;  // R3
    make_pkt(MB + 1, 16'h86DD, 8'h45, 8'd64, 32'h0A09_0909, 1, 64);
    run_pkt(8'h04, 0, 8'h08, "R3");
    make_pkt(MB + 0, 16'h0800, 8'h46, 8'd64, 32'h0A09_0909, 1, 64);
    run_pkt(8'h01, 0, 8'h02, "R3");
    make_pkt(MB + 3, 16'h0800, 8'h45, 8'd64, 32'h0A09_0909, 1, 20);
    run_pkt(8'h40, 0, 8'h80, "R3");
  endtask

  task automatic t_cpu_src;  // R9
    make_pkt(48'hFFFF_FFFF_FFFF, 16'h0800, 8'h45, 8'd1, 32'h0A09_0909, 0, 64);
    run_pkt(8'h08, 0, 8'h04, "R9");
  endtask

  task automatic t_backpressure;  // R11 R10
    bp = 1;
    make_pkt(MB + 0, 16'h0800, 8'h45, 8'd9, 32'h0A01_02C8, 1, 96);
    prep_fwd(MAC_C, 2'd3);
    run_pkt(8'h01, 0, 8'h40, "R11");
    bp = 0;
  endtask

  task automatic t_table_update;  // R13
    wr_route(0, 1, 32'h0A00_0000, 32'hFF00_0000, 32'hC0A8_0303, 2'd0);
    make_pkt(MB + 2, 16'h0800, 8'h45, 8'd64, 32'h0A09_0909, 1, 64);
    prep_fwd(MAC_C, 2'd0);
    run_pkt(8'h10, 0, 8'h01, "R13");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    #1 rst_n = 1;
    t_tables;
    t_fwd_basic;
    t_lpm;
    t_direct;
    t_misses;
    t_ttl;
    t_drops;
    t_nonip;
    t_cpu_src;
    t_backpressure;
    t_table_update;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule